// File: doc/BRIEF.md
# Dual-Threshold Error-Count Health Monitor

This block follows the error history of a single monitored component and assigns it a service level: full service, restricted service, or out of service. Every error pulse raises a saturating counter. Every decay tick lowers it. Two thresholds split the count range into a healthy band, a degraded band and a lockout region.

A component that climbs past the lower threshold is restricted. It earns full service back once its count drops below that threshold again. A component that climbs past the upper threshold is locked out until the next reset, and its count stops moving. A flag tells an error history that still looks transient (small and non-zero) from one that looks persistent.

The thresholds are taken once, at the first clock after reset. If they are ordered wrongly, the block raises a configuration error and stays at full service.

Top module: `err_health_mon`

## Requirements
- R1: While rst_ni is low, count_o is 0, state_o is 2'b00 (full service), and transient_o and cfg_err_o are 0.
- R2: thr_lo_i and thr_hi_i are captured on the first rising clock edge after reset is released. Error and tick inputs are ignored on that edge. Later changes on the threshold inputs have no effect until the next reset.
- R3: An error pulse without a tick raises count_o by one, saturating at 2^CNT_W-1. A tick without an error pulse lowers count_o by one, saturating at 0. Both take effect on the same edge that samples them.
- R4: An error pulse and a tick in the same cycle leave count_o unchanged.
- R5: From full service, a count above the captured lower threshold moves state_o to 2'b01 (restricted) on the same edge that updates the count.
- R6: From restricted service, a count below the lower threshold returns state_o to 2'b00. A count equal to the lower threshold keeps the present state.
- R7: A count above the captured upper threshold sets state_o to 2'b10 (out of service). This state is left only by reset, and count_o is frozen while in it.
- R8: If the captured lower threshold is not strictly less than the upper one, cfg_err_o is 1 and state_o stays 2'b00 while the count keeps tracking events.
- R9: transient_o is 1 exactly when count_o is non-zero and not greater than the captured lower threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| err_i | input | 1 | Error event pulse, one per cycle |
| tick_i | input | 1 | Decay tick |
| thr_lo_i | input | CNT_W | Lower (restrict) threshold |
| thr_hi_i | input | CNT_W | Upper (lockout) threshold |
| state_o | output | 2 | Service state: 00 full, 01 restricted, 10 out |
| count_o | output | CNT_W | Current error count |
| transient_o | output | 1 | Error history looks transient |
| cfg_err_o | output | 1 | Threshold ordering is invalid |

## Verification
The count, the service state and the configuration flag are all registered on the same rising edge that samples an event, and the transient flag follows the count combinationally. Each result is therefore due one edge after its stimulus, with no extra latency. The bench drives inputs after a falling edge and checks every output one time unit after the next rising edge, against an arithmetic model that it advances at that same edge. The threshold capture edge is modelled as a separate step so that events on it are expected to be dropped. Every lower/upper threshold pair of a 4-bit counter is swept through ramps up, decays, cancelled pairs and a lockout.

// File: rtl/err_health_pkg.sv
package err_health_pkg;
  typedef enum logic [1:0] {
    SVC_FULL     = 2'b00,
    SVC_RESTRICT = 2'b01,
    SVC_OUT      = 2'b10
  } svc_state_e;
endpackage

// File: rtl/ehm_cfg.sv
module ehm_cfg #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] thr_lo_i,
  input  logic [CNT_W-1:0] thr_hi_i,
  output logic [CNT_W-1:0] lo_o,
  output logic [CNT_W-1:0] hi_o,
  output logic             loaded_o,
  output logic             cfg_err_o
);
  logic [CNT_W-1:0] lo_q, hi_q;
  logic             loaded_q;

  // single capture after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      hi_q     <= '0;
      loaded_q <= 1'b0;
    end else if (!loaded_q) begin
      lo_q     <= thr_lo_i;
      hi_q     <= thr_hi_i;
      loaded_q <= 1'b1;
    end
  end

  assign lo_o      = lo_q;
  assign hi_o      = hi_q;
  assign loaded_o  = loaded_q;
  assign cfg_err_o = loaded_q && (lo_q >= hi_q);
endmodule

// File: rtl/ehm_counter.sv
module ehm_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) begin
      if (inc_i && !dec_i && cnt_q != CntMax) cnt_d = cnt_q + 1'b1;
      else if (dec_i && !inc_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;
endmodule

// File: rtl/ehm_fsm.sv
module ehm_fsm
  import err_health_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cfg_err_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  output svc_state_e       state_o
);
  svc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (en_i) begin
      if (cfg_err_i)             state_d = SVC_FULL;
      else if (cnt_nxt_i > hi_i) state_d = SVC_OUT;
      else if (cnt_nxt_i > lo_i) state_d = SVC_RESTRICT;
      else if (cnt_nxt_i < lo_i) state_d = SVC_FULL;
      // equal to lower threshold: hold (hysteresis)
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SVC_FULL;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/err_health_mon.sv
module err_health_mon
  import err_health_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] thr_lo_i,
  input  logic [CNT_W-1:0] thr_hi_i,
  output logic [1:0]       state_o,
  output logic [CNT_W-1:0] count_o,
  output logic             transient_o,
  output logic             cfg_err_o
);
  logic [CNT_W-1:0] lo, hi, cnt, cnt_nxt;
  logic             loaded, cfg_err, en;
  svc_state_e       state;

  ehm_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .thr_lo_i  (thr_lo_i),
    .thr_hi_i  (thr_hi_i),
    .lo_o      (lo),
    .hi_o      (hi),
    .loaded_o  (loaded),
    .cfg_err_o (cfg_err)
  );

  // frozen before capture and after lockout
  assign en = loaded && (state != SVC_OUT);

  ehm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .inc_i     (err_i),
    .dec_i     (tick_i),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt)
  );

  ehm_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .cfg_err_i (cfg_err),
    .cnt_nxt_i (cnt_nxt),
    .lo_i      (lo),
    .hi_i      (hi),
    .state_o   (state)
  );

  assign state_o     = state;
  assign count_o     = cnt;
  assign cfg_err_o   = cfg_err;
  assign transient_o = (cnt != '0) && (cnt <= lo);
endmodule

// File: rtl/err_health_mon_chk.sv
module err_health_mon_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             err_i,
  input logic             tick_i,
  input logic [1:0]       state_o,
  input logic [CNT_W-1:0] count_o,
  input logic             cfg_err_o
);
  AST_OUT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b10 |=> state_o == 2'b10); // R7

  AST_OUT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b10 |=> $stable(count_o)); // R7

  AST_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i && tick_i |=> $stable(count_o)); // R4

  AST_CFG_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> state_o == 2'b00); // R8

  AST_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1)
             || (count_o == $past(count_o) - 1'b1)); // R3

  AST_NO_TICK_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> count_o >= $past(count_o)); // R3

  AST_LEGAL_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'b11); // R5
endmodule

bind err_health_mon err_health_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .err_i     (err_i),
  .tick_i    (tick_i),
  .state_o   (state_o),
  .count_o   (count_o),
  .cfg_err_o (cfg_err_o)
);

// File: tb/err_health_mon_tb_top.sv
`timescale 1ns/1ps
module err_health_mon_tb_top;
  localparam int CNT_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             err_i = 1'b0;
  logic             tick_i = 1'b0;
  logic [CNT_W-1:0] thr_lo_i = '0;
  logic [CNT_W-1:0] thr_hi_i = '0;
  logic [1:0]       state_o;
  logic [CNT_W-1:0] count_o;
  logic             transient_o;
  logic             cfg_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench model
  int  m_cnt, m_st, m_lo, m_hi;
  bit  m_loaded;

  always #4 clk_i = ~clk_i;

  err_health_mon #(.CNT_W(CNT_W)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .err_i       (err_i),
    .tick_i      (tick_i),
    .thr_lo_i    (thr_lo_i),
    .thr_hi_i    (thr_hi_i),
    .state_o     (state_o),
    .count_o     (count_o),
    .transient_o (transient_o),
    .cfg_err_o   (cfg_err_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (lo=%0d hi=%0d)", req, act, exp, m_lo, m_hi);
    end
  endtask

  task automatic check_all(input string tag);
    bit cfg_exp, tr_exp;
    cfg_exp = m_loaded && (m_lo >= m_hi);
    tr_exp  = (m_cnt != 0) && (m_cnt <= m_lo);
    check({tag, " R3 count"}, count_o, m_cnt);
    check({tag, " R5 R6 R7 state"}, state_o, m_st);
    check({tag, " R9 transient"}, transient_o, tr_exp);
    check({tag, " R8 cfg_err"}, cfg_err_o, cfg_exp);
  endtask

  task automatic do_reset(input int lo, input int hi);
    @(negedge clk_i);
    rst_ni = 1'b0; err_i = 1'b0; tick_i = 1'b0;
    thr_lo_i = lo[CNT_W-1:0]; thr_hi_i = hi[CNT_W-1:0];
    @(negedge clk_i);
    check("R1 count in reset", count_o, 0);
    check("R1 state in reset", state_o, 0);
    check("R1 transient in reset", transient_o, 0);
    check("R1 cfg_err in reset", cfg_err_o, 0);
    rst_ni = 1'b1;
    m_cnt = 0; m_st = 0; m_loaded = 0; m_lo = 0; m_hi = 0;
  endtask

  // drive at negedge, check just after the next posedge
  task automatic step(input bit e, input bit t, input string tag);
    err_i = e; tick_i = t;
    @(posedge clk_i);
    #1;
    if (!m_loaded) begin
      m_lo = thr_lo_i; m_hi = thr_hi_i; m_loaded = 1;
    end else if (m_st != 2) begin
      if (e && !t) m_cnt = (m_cnt < CMAX) ? m_cnt + 1 : CMAX;
      else if (t && !e) m_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
      if (m_lo >= m_hi)      m_st = 0;
      else if (m_cnt > m_hi) m_st = 2;
      else if (m_cnt > m_lo) m_st = 1;
      else if (m_cnt < m_lo) m_st = 0;
    end
    check_all(tag);
    @(negedge clk_i);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R2: events on the capture edge are dropped
    do_reset(2, 5);
    step(1, 0, "R2 capture edge");
    check("R2 count after capture edge", count_o, 0);
    // R4: cancelling pair at a mid value
    step(1, 0, "R4 pre");
    step(1, 0, "R4 pre");
    step(1, 1, "R4 cancel");
    check("R4 cancel keeps count", count_o, 2);

    for (int lo = 0; lo <= CMAX; lo++) begin
      for (int hi = 0; hi <= CMAX; hi++) begin
        do_reset(lo, hi);
        step(0, 0, "R2 load");
        // R2: later threshold changes must be ignored
        thr_lo_i = CNT_W'(CMAX - lo);
        thr_hi_i = CNT_W'(CMAX - hi);
        step(0, 1, "R3 floor");
        for (int k = 0; k < hi; k++) step(1, 0, "R5 ramp");
        step(1, 1, "R4 pair");
        for (int k = 0; k <= CMAX + 1; k++) step(0, 1, "R6 decay");
        for (int k = 0; k <= CMAX + 1; k++) step(1, 0, "R7 climb");
        step(1, 1, "R4 pair late");
        step(0, 1, "R7 frozen");
        step(0, 1, "R7 frozen");
        step(1, 0, "R3 ceiling");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule